// File: doc/BRIEF.md
# Prescaled Down-Counting Timer Channel

This block is a single down-counting timer channel. It has a small byte-wide register port. Through it, software programs a five-bit control word and a reload value, and it reads back either the control word or the live count. The count advances on "ticks", and the source of a tick depends on the mode:
- **Delay mode:** a prescaler fed by the system clock produces ticks, so the channel is periodic.
- **Event mode:** ticks come from active edges on the timer input pin.
- **Pulse-width mode:** ticks come from the prescaler, but only while the input sits at its active level.

When the count reaches one, the next tick reloads it from the data register. The same tick toggles the timer output and raises a one-cycle interrupt strobe. In pulse-width mode the trailing edge of the measured pulse raises a second, separate strobe. A polarity input selects which level or edge of the pin counts as active.

Top module: `tmr_channel`

## Requirements
- R1: After reset the counter, reload value and control word are zero, and the timer output and both strobes are low.
- R2: The low four control bits select the mode: 0 stops the timer, 1 to 7 select delay mode, 8 selects event mode and 9 to 15 select pulse-width mode. A control write keeps only bits 4:0, and reading with `rd_sel`=0 returns them zero-extended. While the timer is stopped, the counter changes only through a data write.
- R3: In delay and pulse-width modes, control bits 2:0 are a prescale code. Codes 1 to 7 produce one tick every 4, 10, 16, 50, 64, 100 and 200 clock cycles respectively.
- R4: On a tick with the counter equal to 1, the counter reloads, the timer output toggles and `tmr_irq` is high for exactly the next cycle. On any other tick the counter decrements by one. With no tick and no write, the counter holds.
- R5: A data write (`wr_sel`=1) always updates the reload value. It loads the counter directly only while the timer is stopped.
- R6: A read with `rd_sel`=1 returns the live counter value.
- R7: In event mode, one tick occurs on each clock where (`tin` XOR `edge_pol`) has gone from 1 to 0 since the previous clock.
- R8: In pulse-width mode, the prescaler advances only on clocks where `tin` equals `edge_pol`. On other clocks it and the counter hold.
- R9: In pulse-width mode, a change of (`tin` XOR `edge_pol`) from 0 to 1 makes `pend_irq` high for exactly one cycle. `pend_irq` never fires in the other modes.
- R10: A control write with bit 4 set forces the timer output to 0. This takes priority over a toggle in the same cycle.
- R11: A reload value of 0 gives 256 ticks between reloads.
- R12: A control write that changes the prescale code restarts the prescaler from zero. The prescaler is also held at zero while the timer is stopped or in event mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, also the prescaler source |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control word, 1 data/reload |
| wr_data | input | DATA_W | Write data |
| rd_sel | input | 1 | Read source: 0 control word, 1 live counter |
| rd_data | output | DATA_W | Read data, combinational from `rd_sel` |
| tin | input | 1 | Timer input pin, synchronous to `clk` |
| edge_pol | input | 1 | Active-edge/level polarity for `tin` |
| tout | output | 1 | Timer output, toggles on each reload |
| tmr_irq | output | 1 | One-cycle strobe on each reload |
| pend_irq | output | 1 | One-cycle strobe at the end of a measured pulse |

## Verification
On every cycle, the embedded properties check the following:
- The prescaler never leaves the range set by the current divisor.
- The counter holds unless a tick or a data write occurred.
- A stopped timer keeps its count.
- Each reload strobe lasts one cycle and coincides with an output toggle.
- The pulse-end strobe appears only in pulse-width mode.

Only the bench's scenarios can show the following:
- The exact divisor for each prescale code.
- The 256-tick period of a zero reload.
- Which edge direction counts under each polarity.
- The prescaler restart after a code change.
- The gating of pulse-width counting by the input level.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int PRE_W  = 8;
    localparam int CTRL_W = 5;

    typedef enum logic [1:0] {
        MODE_STOP,
        MODE_DELAY,
        MODE_EVENT,
        MODE_PULSE
    } tmr_mode_e;

    function automatic tmr_mode_e decode_mode(input logic [3:0] sel);
        if (sel == 4'd0)      return MODE_STOP;
        else if (sel == 4'd8) return MODE_EVENT;
        else if (sel[3])      return MODE_PULSE;
        else                  return MODE_DELAY;
    endfunction

    function automatic logic [PRE_W-1:0] pre_divisor(input logic [2:0] code);
        logic [PRE_W-1:0] div;
        case (code)
            3'd1:    div = PRE_W'(4);
            3'd2:    div = PRE_W'(10);
            3'd3:    div = PRE_W'(16);
            3'd4:    div = PRE_W'(50);
            3'd5:    div = PRE_W'(64);
            3'd6:    div = PRE_W'(100);
            3'd7:    div = PRE_W'(200);
            default: div = PRE_W'(1);
        endcase
        return div;
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clear,
    input  logic [PRE_W-1:0] divisor,
    output logic             tick
);

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_state_t;

    pre_state_t pre_d, pre_q;

    always_comb begin
        pre_d = pre_q;
        tick  = run && (pre_q.cnt == divisor - PRE_W'(1));
        if (run) begin
            pre_d.cnt = tick ? '0 : pre_q.cnt + PRE_W'(1);
        end
        if (clear) begin
            pre_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    // R3
    pre_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q.cnt < divisor);

endmodule

// File: rtl/tmr_edge.sv
module tmr_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic tin,
    input  logic pol,
    output logic lvl,
    output logic fall,
    output logic rise
);

    typedef struct packed {
        logic lvl;
    } edge_state_t;

    edge_state_t edge_d, edge_q;

    always_comb begin
        lvl        = tin ^ pol;
        edge_d.lvl = lvl;
        fall       = edge_q.lvl && !lvl;
        rise       = !edge_q.lvl && lvl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) edge_q <= '0;
        else        edge_q <= edge_d;
    end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_sel,
    output logic [DATA_W-1:0] rd_data,
    input  logic              tin,
    input  logic              edge_pol,
    output logic              tout,
    output logic              tmr_irq,
    output logic              pend_irq
);

    typedef struct packed {
        logic [DATA_W-1:0] cnt;
        logic [DATA_W-1:0] reload;
        logic [CTRL_W-1:0] ctrl;
        logic              tout;
        logic              irq;
        logic              pend;
    } chan_state_t;

    chan_state_t ch_d, ch_q;

    tmr_mode_e        mode;
    logic [PRE_W-1:0] divisor;
    logic             pre_run;
    logic             pre_clear;
    logic             pre_tick;
    logic             in_lvl;
    logic             in_fall;
    logic             in_rise;
    logic             count_tick;
    logic             ctrl_wr;
    logic             data_wr;

    assign mode    = decode_mode(ch_q.ctrl[3:0]);
    assign divisor = pre_divisor(ch_q.ctrl[2:0]);
    assign ctrl_wr = wr_en && !wr_sel;
    assign data_wr = wr_en && wr_sel;

    assign pre_run   = (mode == MODE_DELAY) || ((mode == MODE_PULSE) && !in_lvl);
    assign pre_clear = (mode == MODE_STOP) || (mode == MODE_EVENT) ||
                       (ctrl_wr && (wr_data[2:0] != ch_q.ctrl[2:0]));

    tmr_edge edge_i (
        .clk   (clk),
        .rst_n (rst_n),
        .tin   (tin),
        .pol   (edge_pol),
        .lvl   (in_lvl),
        .fall  (in_fall),
        .rise  (in_rise)
    );

    tmr_prescaler pre_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (pre_run),
        .clear   (pre_clear),
        .divisor (divisor),
        .tick    (pre_tick)
    );

    assign count_tick = pre_tick || ((mode == MODE_EVENT) && in_fall);

    always_comb begin
        ch_d      = ch_q;
        ch_d.irq  = 1'b0;
        ch_d.pend = (mode == MODE_PULSE) && in_rise;
        if (count_tick) begin
            if (ch_q.cnt == DATA_W'(1)) begin
                ch_d.cnt  = ch_q.reload;
                ch_d.tout = !ch_q.tout;
                ch_d.irq  = 1'b1;
            end else begin
                ch_d.cnt = ch_q.cnt - DATA_W'(1);
            end
        end
        if (data_wr) begin
            ch_d.reload = wr_data;
            if (mode == MODE_STOP) begin
                ch_d.cnt = wr_data;
            end
        end
        if (ctrl_wr) begin
            ch_d.ctrl = wr_data[CTRL_W-1:0];
            if (wr_data[4]) begin
                ch_d.tout = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ch_q <= '0;
        else        ch_q <= ch_d;
    end

    assign rd_data  = rd_sel ? ch_q.cnt : DATA_W'(ch_q.ctrl);
    assign tout     = ch_q.tout;
    assign tmr_irq  = ch_q.irq;
    assign pend_irq = ch_q.pend;

    // R4
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!count_tick && !data_wr) |=> (ch_q.cnt == $past(ch_q.cnt)));

    // R2
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MODE_STOP) && !data_wr) |=> (ch_q.cnt == $past(ch_q.cnt)));

    // R4
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_irq |=> !tmr_irq);

    // R4
    irq_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_irq && !$past(ctrl_wr && wr_data[4])) |-> (tout != $past(tout)));

    // R9
    pend_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_irq |-> ($past(mode) == MODE_PULSE));

    // R9
    pend_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_irq |=> !pend_irq);

endmodule

// File: tb/tmr_channel_tb.sv
`timescale 1ns/100ps
module tmr_channel_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_sel = 1'b1;
    logic [7:0] rd_data;
    logic       tin = 1'b0;
    logic       edge_pol = 1'b0;
    logic       tout;
    logic       tmr_irq;
    logic       pend_irq;

    int    n_chk = 0;
    int    n_fail = 0;
    string phase = "R1";

    always #2.5 clk = !clk;

    tmr_channel #(.DATA_W(8)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .rd_sel   (rd_sel),
        .rd_data  (rd_data),
        .tin      (tin),
        .edge_pol (edge_pol),
        .tout     (tout),
        .tmr_irq  (tmr_irq),
        .pend_irq (pend_irq)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Behavioural reference model
    int m_cnt, m_rel, m_ctrl, m_tout, m_irq, m_pend, m_pre, m_prev;

    function automatic int div_of(input int code);
        case (code)
            1: return 4;   2: return 10;  3: return 16;  4: return 50;
            5: return 64;  6: return 100; 7: return 200;
            default: return 1;
        endcase
    endfunction

    always @(posedge clk) begin
        int lvl, md, dv, tk, wasstop;
        if (!rst_n) begin
            m_cnt = 0; m_rel = 0; m_ctrl = 0; m_tout = 0;
            m_irq = 0; m_pend = 0; m_pre = 0; m_prev = 0;
        end else begin
            lvl = (tin ^ edge_pol) ? 1 : 0;
            md = m_ctrl % 16;
            dv = div_of(m_ctrl % 8);
            tk = 0;
            wasstop = (md == 0);
            if ((md >= 1 && md <= 7) || (md >= 9 && lvl == 0)) begin
                if (m_pre == dv - 1) begin tk = 1; m_pre = 0; end
                else m_pre = m_pre + 1;
            end else if (md == 0 || md == 8) begin
                m_pre = 0;
            end
            if (md == 8 && m_prev == 1 && lvl == 0) tk = 1;
            m_pend = (md >= 9 && m_prev == 0 && lvl == 1) ? 1 : 0;
            m_irq = 0;
            if (tk == 1) begin
                if (m_cnt == 1) begin m_cnt = m_rel; m_tout = 1 - m_tout; m_irq = 1; end
                else m_cnt = (m_cnt + 255) % 256;
            end
            if (wr_en && wr_sel) begin
                m_rel = wr_data;
                if (wasstop) m_cnt = wr_data;
            end
            if (wr_en && !wr_sel) begin
                if ((wr_data % 8) != (m_ctrl % 8)) m_pre = 0;
                if (wr_data[4]) m_tout = 0;
                m_ctrl = wr_data % 32;
            end
            m_prev = lvl;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            int exp_rd;
            exp_rd = rd_sel ? m_cnt : m_ctrl;
            chk(rd_data == exp_rd, {phase, " read"}, rd_data, exp_rd);
            chk(tout == m_tout, {phase, " tout"}, tout, m_tout);
            chk(tmr_irq == m_irq, {phase, " tmr_irq"}, tmr_irq, m_irq);
            chk(pend_irq == m_pend, {phase, " pend_irq"}, pend_irq, m_pend);
        end
    end

    task automatic wr(input bit sel, input int v);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_sel = sel; wr_data = v[7:0];
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wait_irq(output int cyc);
        cyc = 1;
        @(negedge clk);
        while (!tmr_irq) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic set_tin(input bit v, input int hold);
        @(posedge clk); #1;
        tin = v;
        idle(hold);
    endtask

    task automatic finish_up;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_up();
    end

    initial begin
        int p, pend_n, t0;
        idle(3);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(rd_data == 0 && tout == 0 && tmr_irq == 0 && pend_irq == 0, "R1 reset", rd_data, 0);
        rd_sel = 1'b0;
        @(negedge clk);
        chk(rd_data == 0, "R1 control reset", rd_data, 0);
        rd_sel = 1'b1;

        // R5 data write while stopped loads counter
        phase = "R5";
        wr(1, 2);
        @(negedge clk);
        chk(rd_data == 2, "R5 stopped load", rd_data, 2);

        // R2 control keeps bits 4:0
        phase = "R2";
        wr(0, 8'hE1);
        rd_sel = 1'b0;
        @(negedge clk);
        chk(rd_data == 8'h01, "R2 control readback", rd_data, 1);
        rd_sel = 1'b1;

        // R4 / R3: reload 2, divide by 4 -> period 8
        phase = "R4";
        wait_irq(p);
        wait_irq(p);
        chk(p == 8, "R4 period div4 data2", p, 8);

        // R5 running write only changes reload
        phase = "R5";
        wr(1, 5);
        @(negedge clk);
        chk(rd_data <= 2, "R5 running write keeps counter", rd_data, 2);
        wait_irq(p);
        wait_irq(p);
        chk(p == 20, "R5 new reload period", p, 20);

        // R3 every prescale code with reload 1
        phase = "R3";
        for (int c = 2; c <= 7; c++) begin
            wr(0, 0);
            wr(1, 1);
            wr(0, c);
            wait_irq(p);
            wait_irq(p);
            chk(p == div_of(c), "R3 prescale period", p, div_of(c));
        end

        // R11 reload 0 means 256 ticks
        phase = "R11";
        wr(0, 0);
        wr(1, 0);
        wr(0, 1);
        wait_irq(p);
        wait_irq(p);
        chk(p == 1024, "R11 zero reload period", p, 1024);

        // R10 force output low
        phase = "R10";
        wr(0, 0);
        wr(1, 1);
        wr(0, 1);
        while (tout != 1'b1) @(negedge clk);
        wr(0, 8'h11);
        @(negedge clk);
        chk(tout == 0, "R10 force low", tout, 0);

        // R12 prescale code change restarts prescaler
        phase = "R12";
        wr(0, 0);
        wr(1, 1);
        wr(0, 7);
        idle(150);
        wr(0, 1);
        wait_irq(p);
        chk(p <= 6, "R12 restart after code change", p, 4);

        // R7 event mode, polarity 0: falling input counts
        phase = "R7";
        wr(0, 0);
        edge_pol = 1'b0; tin = 1'b0;
        wr(1, 3);
        wr(0, 8);
        set_tin(1, 2);
        @(negedge clk);
        chk(rd_data == 3, "R7 rising ignored", rd_data, 3);
        set_tin(0, 2);
        set_tin(1, 2);
        set_tin(0, 2);
        @(negedge clk);
        chk(rd_data == 1, "R6 live counter after two events", rd_data, 1);
        t0 = tout;
        set_tin(1, 2);
        set_tin(0, 2);
        @(negedge clk);
        chk(rd_data == 3 && tout != t0, "R7 reload on third event", rd_data, 3);

        // R7 event mode, polarity 1: rising input counts
        wr(0, 0);
        edge_pol = 1'b1; tin = 1'b1;
        wr(1, 2);
        idle(2);
        wr(0, 8);
        set_tin(0, 2);
        @(negedge clk);
        chk(rd_data == 2, "R7 pol1 falling ignored", rd_data, 2);
        set_tin(1, 2);
        @(negedge clk);
        chk(rd_data == 1, "R7 pol1 rising counts", rd_data, 1);

        // R8 / R9 pulse-width mode
        phase = "R8";
        wr(0, 0);
        edge_pol = 1'b1; tin = 1'b0;
        wr(1, 200);
        idle(2);
        wr(0, 9);
        idle(40);
        @(negedge clk);
        chk(rd_data == 200, "R8 gated while inactive", rd_data, 200);
        tin = 1'b1;
        idle(40);
        @(negedge clk);
        chk(rd_data == 190, "R8 counts while active", rd_data, 190);
        phase = "R9";
        pend_n = 0;
        tin = 1'b0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (pend_irq) pend_n++;
        end
        chk(pend_n == 1, "R9 one pulse-end strobe", pend_n, 1);
        chk(rd_data == 190, "R8 holds after pulse", rd_data, 190);

        // R9 no pulse-end strobe outside pulse mode
        wr(0, 1);
        pend_n = 0;
        for (int i = 0; i < 4; i++) begin
            set_tin(1, 2);
            set_tin(0, 2);
            if (pend_irq) pend_n++;
        end
        chk(pend_n == 0, "R9 silent in delay mode", pend_n, 0);

        idle(5);
        finish_up();
    end

endmodule